// File: doc/BRIEF.md
# Two-Phase Shared-Bus Accumulator CPU Core

This block is a 16-bit CPU core with two instruction classes. It talks to one memory through a single address bus, a read-data bus, a write-data bus and a write strobe. Instructions and data travel over the same bus, so the core alternates between two kinds of clock cycle. In a fetch cycle it reads the next instruction word from the upper half of the address space and latches it. In an execute cycle it runs the latched instruction. That cycle may read a data operand from, or write a result to, any 16-bit address.

Programs are placed at word address 0x8000 and up. Data lives below 0x8000. A data pointer with bit 15 set reaches the program region, so a program can read constants out of its own image. The core holds an address register A, a data register D, a 15-bit program counter and an instruction register.

Top module: `fe_core`

## Requirements
- R1: A phase bit alternates on every clock, fetch then execute, so each instruction occupies exactly two cycles. The first cycle after `rst_n` returns high is a fetch.
- R2: While `rst_n` is low at a rising edge (synchronous, active low), the PC, A and D clear to 0 and the phase returns to fetch. The first fetch after reset therefore presents address 0x8000.
- R3: In a fetch cycle `mem_addr` equals {1, PC[14:0]}.
- R4: In an execute cycle `mem_addr` equals all 16 bits of A. A pointer with bit 15 set therefore reads the upper region.
- R5: The instruction register captures `mem_rdata` only at the end of a fetch cycle and holds it through the execute cycle that follows.
- R6: The PC increments by one at the end of every fetch cycle. At the end of an execute cycle it loads A[14:0] if the jump condition holds; otherwise it is unchanged.
- R7: An instruction with bit 15 = 0 loads its whole 16-bit word into A in its execute cycle.
- R8: `mem_we` is high only in the execute cycle of an instruction with bit 15 = 1 and bit 3 = 1. It is never high in a fetch cycle or while `rst_n` is low.
- R9: For an instruction with bit 15 = 1, the ALU operands are fixed as follows:
  - x is D.
  - y is the read data when bit 12 = 1, and A otherwise.
  - Bits 11..6 apply, in order: zero x, invert x, zero y, invert y, add (1) or AND (0), and invert the result.
  - The result appears on `mem_wdata`.
  - Bit 5 loads A, bit 4 loads D and bit 3 writes memory.
- R10: A compute instruction jumps when (bit 2 and result < 0), or (bit 1 and result = 0), or (bit 0 and result > 0). With bits 2..0 = 111 the jump is unconditional.
- R11: When bit 5 and bit 3 are both set, the memory write goes to the A value held before the instruction, not to the new A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Shared address bus for instructions and data |
| mem_rdata | input | 16 | Read data from memory (instruction or operand) |
| mem_wdata | output | 16 | ALU result driven as write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
Three situations are hard to reach from the ports.

- A read-modify-write that also retargets A (R11). The write address must come from the old A while the new A is being computed from the same memory word. The program sets this up with a single instruction that increments memory and stores the result into both A and memory.
- A data pointer with bit 15 set (R4). An A-type word cannot carry bit 15, so the program builds 0x8003 arithmetically, then reads its own code word through it and stores that word back into data memory.
- A reset asserted in the middle of an execute phase. The bench waits until the reference model reports execute, pulls reset for one cycle, and checks that the restart is a clean fetch from 0x8000.

// File: rtl/fe_pkg.sv
// Shared types for the two-phase CPU core.
// Assumes the compute-instruction control field occupies the low 13 bits.
package fe_pkg;

    localparam int CTL_W = 13;

    // Control field of a compute instruction, most significant bit first.
    typedef struct packed {
        logic sel_m;   // y operand: 1 = read data, 0 = A
        logic zx;      // zero x
        logic nx;      // invert x
        logic zy;      // zero y
        logic ny;      // invert y
        logic f_add;   // 1 = add, 0 = AND
        logic no;      // invert result
        logic dst_a;   // load A
        logic dst_d;   // load D
        logic dst_m;   // write memory
        logic j_neg;   // jump if result < 0
        logic j_zero;  // jump if result = 0
        logic j_pos;   // jump if result > 0
    } ctl_t;

endpackage

// File: rtl/fe_phase.sv
// Phase toggle: alternates fetch (0) and execute (1) on every clock.
// Assumes a synchronous active-low reset that returns the phase to fetch.
module fe_phase (
    input  logic clk,
    input  logic rst_n,
    output logic exec_o
);
    logic exec_q;

    // Toggle the phase each cycle; reset forces fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) exec_q <= 1'b0;
        else        exec_q <= ~exec_q;
    end

    assign exec_o = exec_q;

    // R1
    phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (exec_q != $past(exec_q)));

endmodule

// File: rtl/fe_alu.sv
// Six-control-bit ALU: x is D, y is A or read data.
// Assumes the control struct from fe_pkg; purely combinational.
module fe_alu
    import fe_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  ctl_t              ctl_i,
    output logic [WORD_W-1:0] res_o,
    output logic              zero_o,
    output logic              neg_o
);
    logic [WORD_W-1:0] xa, xb, ya, yb, core;

    // Apply the operand conditioning, the operation and the output inversion.
    always_comb begin
        xa   = ctl_i.zx ? '0 : x_i;
        xb   = ctl_i.nx ? ~xa : xa;
        ya   = ctl_i.zy ? '0 : y_i;
        yb   = ctl_i.ny ? ~ya : ya;
        core = ctl_i.f_add ? (xb + yb) : (xb & yb);
        res_o = ctl_i.no ? ~core : core;
    end

    assign zero_o = (res_o == '0);
    assign neg_o  = res_o[WORD_W-1];

endmodule

// File: rtl/fe_branch.sv
// Jump decision from ALU flags and the three condition bits.
// Assumes en_i is high only in the execute phase of a compute instruction.
module fe_branch
    import fe_pkg::*;
(
    input  logic en_i,
    input  ctl_t ctl_i,
    input  logic zero_i,
    input  logic neg_i,
    output logic take_o
);
    logic pos;

    // Combine the less/equal/greater tests with the condition bits.
    always_comb begin
        pos    = ~zero_i & ~neg_i;
        take_o = en_i & ((ctl_i.j_neg & neg_i) | (ctl_i.j_zero & zero_i) | (ctl_i.j_pos & pos));
    end

endmodule

// File: rtl/fe_core.sv
// Two-phase CPU core on one shared memory bus.
// Fetch: address {1, PC}, instruction latched, PC incremented.
// Execute: address is A, the latched instruction updates A/D/PC and may write.
// Assumes memory returns read data combinationally in the same cycle.
module fe_core
    import fe_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we
);
    localparam int PC_W = WORD_W - 1;

    logic              exec_q, fetch;
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] a_q, d_q, ir_q;
    logic [WORD_W-1:0] alu_y, alu_res;
    logic              alu_zero, alu_neg, take;
    logic              is_comp, do_ainst, do_cinst;
    ctl_t              ctl;

    fe_phase u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec_o (exec_q)
    );

    // Decode the latched instruction and gate class enables to execute.
    always_comb begin
        fetch    = ~exec_q;
        ctl      = ctl_t'(ir_q[CTL_W-1:0]);
        is_comp  = ir_q[WORD_W-1];
        do_ainst = exec_q & rst_n & ~is_comp;
        do_cinst = exec_q & rst_n & is_comp;
        alu_y    = ctl.sel_m ? mem_rdata : a_q;
    end

    fe_alu #(.WORD_W(WORD_W)) u_alu (
        .x_i    (d_q),
        .y_i    (alu_y),
        .ctl_i  (ctl),
        .res_o  (alu_res),
        .zero_o (alu_zero),
        .neg_o  (alu_neg)
    );

    fe_branch u_branch (
        .en_i   (do_cinst),
        .ctl_i  (ctl),
        .zero_i (alu_zero),
        .neg_i  (alu_neg),
        .take_o (take)
    );

    // Drive the shared bus: program region in fetch, A in execute.
    always_comb begin
        mem_addr  = fetch ? {1'b1, pc_q} : a_q;
        mem_wdata = alu_res;
        mem_we    = do_cinst & ctl.dst_m;
    end

    // Instruction register: captures read data only in fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)     ir_q <= '0;
        else if (fetch) ir_q <= mem_rdata;
    end

    // Program counter: step in fetch, jump target from old A in execute.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc_q <= '0;
        else if (fetch) pc_q <= pc_q + 1'b1;
        else if (take)  pc_q <= a_q[PC_W-1:0];
    end

    // A register: instruction word or ALU result.
    always_ff @(posedge clk) begin
        if (!rst_n)                    a_q <= '0;
        else if (do_ainst)             a_q <= ir_q;
        else if (do_cinst & ctl.dst_a) a_q <= alu_res;
    end

    // D register: ALU result only.
    always_ff @(posedge clk) begin
        if (!rst_n)                    d_q <= '0;
        else if (do_cinst & ctl.dst_d) d_q <= alu_res;
    end

    // R2
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && a_q == '0 && d_q == '0 && !exec_q));

    // R5
    ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> (ir_q == $past(mem_rdata)));

    // R5
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_q |=> (ir_q == $past(ir_q)));

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> ((pc_q - $past(pc_q)) == PC_W'(1)));

    // R6
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_q && !take) |=> (pc_q == $past(pc_q)));

    // R8
    we_exec_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> exec_q);

endmodule

// File: tb/tb_fe_core.sv
// Self-checking bench with a behavioural reference model updated each clock.
module tb_fe_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, mem_wdata;
    logic        mem_we;

    logic [15:0] lo_mem [0:255];
    logic [15:0] hi_mem [0:255];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_valid = 1'b0;
    bit          m_exec;
    logic [14:0] m_pc;
    logic [15:0] m_a, m_d, m_ir;

    fe_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_rd(input logic [15:0] ad);
        return ad[15] ? hi_mem[ad[7:0]] : lo_mem[ad[7:0]];
    endfunction

    always_comb mem_rdata = mem_rd(mem_addr);

    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_addr[15]) hi_mem[mem_addr[7:0]] <= mem_wdata;
            else              lo_mem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    function automatic logic [15:0] cinst(input bit a, input logic [5:0] op,
                                          input logic [2:0] dst, input logic [2:0] jmp);
        return {3'b111, a, op, dst, jmp};
    endfunction

    function automatic logic [15:0] ref_alu(input logic [15:0] x, input logic [15:0] y,
                                            input logic [5:0] op);
        logic [15:0] xv, yv, r;
        xv = op[5] ? 16'd0 : x;
        if (op[4]) xv = ~xv;
        yv = op[3] ? 16'd0 : y;
        if (op[2]) yv = ~yv;
        r = op[1] ? 16'(xv + yv) : (xv & yv);
        if (op[0]) r = ~r;
        return r;
    endfunction

    function automatic logic [15:0] ref_result(input logic [15:0] ins);
        return ref_alu(m_d, ins[12] ? mem_rd(m_a) : m_a, ins[11:6]);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        logic [15:0] r, old_a;
        bit          take;
        if (!rst_n) begin
            m_valid = 1'b1;
            m_exec = 1'b0; m_pc = '0; m_a = '0; m_d = '0; m_ir = '0;
        end else if (m_valid) begin
            if (!m_exec) begin
                m_ir = mem_rd({1'b1, m_pc});
                m_pc = m_pc + 15'd1;
                m_exec = 1'b1;
            end else begin
                old_a = m_a;
                if (!m_ir[15]) begin
                    m_a = m_ir;
                end else begin
                    r = ref_result(m_ir);
                    take = (m_ir[2] && $signed(r) < 0) || (m_ir[1] && r == 16'd0) ||
                           (m_ir[0] && $signed(r) > 0);
                    if (m_ir[5]) m_a = r;
                    if (m_ir[4]) m_d = r;
                    if (take) m_pc = old_a[14:0];
                end
                m_exec = 1'b0;
            end
        end
    end

    // Compare outputs with the model every cycle, away from the edge.
    always @(negedge clk) begin
        logic [15:0] exp_addr;
        bit          exp_we;
        #1;
        if (m_valid && !done) begin
            exp_we = rst_n && m_exec && m_ir[15] && m_ir[3];
            chk(mem_we == exp_we, "R8 write strobe", {15'd0, mem_we}, {15'd0, exp_we});
            if (rst_n) begin
                exp_addr = m_exec ? m_a : {1'b1, m_pc};
                if (m_exec) chk(mem_addr == exp_addr, "R1 R4 R5 R7 execute address", mem_addr, exp_addr);
                else        chk(mem_addr == exp_addr, "R1 R3 R6 R10 fetch address", mem_addr, exp_addr);
                if (exp_we)
                    chk(mem_wdata == ref_result(m_ir), "R9 R11 write data", mem_wdata, ref_result(m_ir));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            lo_mem[i] = 16'd0;
            hi_mem[i] = 16'd0;
        end
        hi_mem[0]  = 16'd100;                          // @100
        hi_mem[1]  = cinst(0, 6'b110000, 3'b010, 3'b000); // D=A
        hi_mem[2]  = 16'd10;                           // @10
        hi_mem[3]  = cinst(0, 6'b001100, 3'b001, 3'b000); // M=D
        hi_mem[4]  = 16'd10;                           // @10
        hi_mem[5]  = cinst(1, 6'b110111, 3'b101, 3'b000); // AM=M+1
        hi_mem[6]  = cinst(0, 6'b010011, 3'b010, 3'b000); // D=D-A
        hi_mem[7]  = 16'd12;                           // @12
        hi_mem[8]  = cinst(0, 6'b001100, 3'b000, 3'b100); // D;JLT taken
        hi_mem[9]  = 16'd0;
        hi_mem[10] = cinst(0, 6'b111111, 3'b011, 3'b000); // skipped
        hi_mem[12] = 16'd32767;                        // @32767
        hi_mem[13] = cinst(0, 6'b110000, 3'b010, 3'b000); // D=A
        hi_mem[14] = 16'd4;                            // @4
        hi_mem[15] = cinst(0, 6'b000010, 3'b100, 3'b000); // A=D+A -> 0x8003
        hi_mem[16] = cinst(1, 6'b110000, 3'b010, 3'b000); // D=M (program word)
        hi_mem[17] = 16'd11;                           // @11
        hi_mem[18] = cinst(0, 6'b001100, 3'b001, 3'b000); // M=D
        hi_mem[19] = 16'd20;                           // @20
        hi_mem[20] = cinst(0, 6'b001100, 3'b000, 3'b010); // D;JEQ not taken
        hi_mem[21] = 16'd25;                           // @25
        hi_mem[22] = cinst(0, 6'b101010, 3'b000, 3'b111); // 0;JMP
        hi_mem[23] = cinst(0, 6'b111111, 3'b010, 3'b000); // skipped
        hi_mem[25] = 16'd25;                           // @25
        hi_mem[26] = cinst(0, 6'b101010, 3'b000, 3'b111); // 0;JMP loop

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(mem_addr == 16'h8000, "R2 first fetch address", mem_addr, 16'h8000);
        chk(mem_we == 1'b0, "R8 no write in fetch", {15'd0, mem_we}, 16'd0);

        repeat (120) @(negedge clk);
        chk(lo_mem[10] == 16'd101, "R11 write used old A", lo_mem[10], 16'd101);
        chk(lo_mem[11] == 16'hE308, "R4 read through upper-region pointer", lo_mem[11], 16'hE308);

        while (!m_exec) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        chk(mem_we == 1'b0, "R8 no write under reset", {15'd0, mem_we}, 16'd0);
        chk(mem_addr == 16'h8000, "R2 reset returns to fetch of 0x8000", mem_addr, 16'h8000);
        rst_n = 1'b1;
        #2;
        chk(mem_addr == 16'h8000, "R2 restart address", mem_addr, 16'h8000);
        @(negedge clk);
        #2;
        chk(mem_addr == 16'd0, "R1 R7 execute follows fetch with A cleared", mem_addr, 16'd0);

        repeat (100) @(negedge clk);
        chk(lo_mem[10] == 16'd101, "R11 rerun result", lo_mem[10], 16'd101);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule